// File: doc/BRIEF.md
# Multicore Coherency Controller Register Block

This block is the memory-mapped register window of a cluster-level coherency controller serving one to four processor cores. A simple bus master reaches it with a byte address, write data, an access size of 1, 2 or 4 bytes, and separate read and write strobes. The block answers reads one clock after the read strobe.

It keeps only two pieces of state: a single enable bit and a 32-bit power-status word with one byte per core. A read-only configuration word is formed from the core-count parameter. Several offsets are known to the decoder but have no function here: an invalidate command, two filter address registers and two access-control registers. They read as zero and writes to them are dropped. Any offset outside the map reads as zero and raises a one-cycle decode-error pulse. A write whose size code is not 1, 2 or 4 is dropped and raises a one-cycle size-error pulse.

Top module: `coh_ctrl_regs`

## Requirements
- R1: After reset, `rdata`, `size_err` and `dec_err` are zero, and reads of the enable register and all four power-status offsets return zero.
- R2: A valid write to offset 0x00 stores only bit 0 of `wdata`. A read of 0x00 returns that bit in bit 0 and zeros in bits 31:1.
- R3: A read of offset 0x04 returns ((2^N − 1) << 4) | (N − 1), where N is `N_CORES`. Writes to 0x04 change nothing.
- R4: A read at offset 0x08+k (k = 0..3) returns the power-status word shifted right by 8·k bits. The vacated upper bits are zero.
- R5: A valid write at 0x08+k replaces power-status bytes k through k+S−1, where S is the size in bytes, with `wdata` bytes 0 through S−1. Bytes above byte 3 are discarded, and the other bytes keep their values.
- R6: The `size` code is the byte count: 1, 2 or 4. A write with any other size code changes no state, and `size_err` is high for exactly the following cycle.
- R7: Offsets 0x0C, 0x40, 0x44, 0x50 and 0x54 read as zero, ignore writes and raise no decode error.
- R8: A read or write at any offset not named in R2 to R7 changes no state. For a read, `rdata` becomes zero. `dec_err` is high for exactly the following cycle.
- R9: `rdata` updates only in the cycle after `rd_en` and otherwise holds its value. A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W (8) | Byte offset into the register window |
| size | input | 3 | Access size in bytes (1, 2 or 4) |
| wdata | input | 32 | Write data, lane 0 in bits 7:0 |
| rdata | output | 32 | Registered read data |
| size_err | output | 1 | Pulse: previous write had an illegal size |
| dec_err | output | 1 | Pulse: previous access hit an unmapped offset |

## Verification
The embedded properties check, on every cycle, that `rdata` holds between reads, that configuration reads return the parameter-derived word, and that inert and unmapped offsets read as zero. They also check that a bad-size write leaves both state words untouched, and that a status write at a nonzero lane leaves byte 0 alone. Only the bench scenarios can show that the byte-lane merge itself is correct for every size and offset combination, including the truncation at the top of the word. The same holds for the sequence behaviour of R2 and R9: the enable bit read back after writes, and old data returned when a read and a write collide.

// File: rtl/coh_regs_pkg.sv
package coh_regs_pkg;

    localparam int DATA_W   = 32;
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_CFG  = 'h04;
    localparam int OFS_PWR  = 'h08;
    localparam int OFS_INV  = 'h0C;
    localparam int OFS_FLO  = 'h40;
    localparam int OFS_FHI  = 'h44;
    localparam int OFS_ACS  = 'h50;
    localparam int OFS_ACN  = 'h54;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_CFG,
        SEL_PWR,
        SEL_RAZ,
        SEL_MISS
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [1:0] lane;
    } dec_t;

    typedef struct packed {
        logic              ok;
        logic [DATA_W-1:0] mask;
    } size_dec_t;

    function automatic size_dec_t decode_size(input logic [2:0] sz);
        size_dec_t r;
        r.ok   = 1'b1;
        r.mask = '0;
        case (sz)
            3'd1:    r.mask = 32'h0000_00FF;
            3'd2:    r.mask = 32'h0000_FFFF;
            3'd4:    r.mask = 32'hFFFF_FFFF;
            default: r.ok   = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_word(input int n);
        logic [DATA_W-1:0] ones;
        ones = (DATA_W'(1) << n) - DATA_W'(1);
        return (ones << 4) | DATA_W'(n - 1);
    endfunction

endpackage

// File: rtl/coh_addr_decode.sv
module coh_addr_decode
    import coh_regs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    always_comb begin
        dec.lane = addr[1:0];
        dec.sel  = SEL_MISS;
        if (addr == ADDR_W'(OFS_CTRL))
            dec.sel = SEL_CTRL;
        else if (addr == ADDR_W'(OFS_CFG))
            dec.sel = SEL_CFG;
        else if (addr >= ADDR_W'(OFS_PWR) && addr <= ADDR_W'(OFS_PWR + 3))
            dec.sel = SEL_PWR;
        else if (addr == ADDR_W'(OFS_INV) || addr == ADDR_W'(OFS_FLO) ||
                 addr == ADDR_W'(OFS_FHI) || addr == ADDR_W'(OFS_ACS) ||
                 addr == ADDR_W'(OFS_ACN))
            dec.sel = SEL_RAZ;
    end
endmodule

// File: rtl/coh_pwr_status.sv
module coh_pwr_status
    import coh_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        lane,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] status
);
    logic [4:0]        shamt;
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] lane_data;

    always_comb begin
        shamt     = {lane, 3'b000};
        lane_mask = mask << shamt;
        lane_data = (wdata & mask) << shamt;
    end

    always_ff @(posedge clk) begin
        if (rst)
            status <= '0;
        else if (we)
            status <= (status & ~lane_mask) | lane_data;
    end

    // R5: a write starting above lane 0 never disturbs byte 0
    p_low_byte_kept_r5: assert property (@(posedge clk) disable iff (rst)
        (we && lane != 2'd0) |=> status[7:0] == $past(status[7:0]));
endmodule

// File: rtl/coh_read_port.sv
module coh_read_port
    import coh_regs_pkg::*;
#(
    parameter int N_CORES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  dec_t              dec,
    input  logic              ctrl,
    input  logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [DATA_W-1:0] CFG = cfg_word(N_CORES);

    logic [DATA_W-1:0] rd_val;

    always_comb begin
        case (dec.sel)
            SEL_CTRL: rd_val = {{(DATA_W-1){1'b0}}, ctrl};
            SEL_CFG:  rd_val = CFG;
            SEL_PWR:  rd_val = status >> {dec.lane, 3'b000};
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_val;
    end

    p_cfg_value_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && dec.sel == SEL_CFG) |=> rdata == CFG);

    p_inert_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && dec.sel == SEL_RAZ) |=> rdata == '0);

    p_miss_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && dec.sel == SEL_MISS) |=> rdata == '0);

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));
endmodule

// File: rtl/coh_ctrl_regs.sv
module coh_ctrl_regs
    import coh_regs_pkg::*;
#(
    parameter int N_CORES = 1,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              size_err,
    output logic              dec_err
);
    dec_t              dec;
    size_dec_t         sdec;
    logic              wr_ok;
    logic              ctrl_q;
    logic [DATA_W-1:0] status;

    coh_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .dec  (dec)
    );

    always_comb begin
        sdec  = decode_size(size);
        wr_ok = wr_en && sdec.ok;
    end

    coh_pwr_status u_pwr (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_ok && dec.sel == SEL_PWR),
        .lane   (dec.lane),
        .mask   (sdec.mask),
        .wdata  (wdata),
        .status (status)
    );

    coh_read_port #(.N_CORES(N_CORES)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (rd_en),
        .dec    (dec),
        .ctrl   (ctrl_q),
        .status (status),
        .rdata  (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= 1'b0;
            size_err <= 1'b0;
            dec_err  <= 1'b0;
        end else begin
            if (wr_ok && dec.sel == SEL_CTRL)
                ctrl_q <= wdata[0];
            size_err <= wr_en && !sdec.ok;
            dec_err  <= (rd_en || wr_en) && dec.sel == SEL_MISS;
        end
    end

    p_bad_size_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !sdec.ok) |=> size_err && $stable(status) && $stable(ctrl_q));

    p_inert_no_err_r7: assert property (@(posedge clk) disable iff (rst)
        ((rd_en || wr_en) && dec.sel == SEL_RAZ) |=> !dec_err);

    p_miss_keeps_state_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.sel == SEL_MISS) |=> dec_err && $stable(status) && $stable(ctrl_q));

    initial p_core_range: assert (N_CORES >= 1 && N_CORES <= 4);
endmodule

// File: tb/sim_coh_ctrl_regs.sv
module sim_coh_ctrl_regs;
    localparam int CLK_PERIOD = 10;
    localparam int N_CORES    = 3;
    localparam int ADDR_W     = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rd_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [2:0]        size = 3'd4;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              size_err;
    logic              dec_err;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    logic        ctrl_m = 1'b0;
    logic [31:0] stat_m = '0;

    coh_ctrl_regs #(.N_CORES(N_CORES), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .size(size), .wdata(wdata), .rdata(rdata), .size_err(size_err),
        .dec_err(dec_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_cfg(input int n);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) r[4+i] = 1'b1;
        return r | 32'(n - 1);
    endfunction

    function automatic bit is_known(input int a);
        return a == 'h00 || a == 'h04 || (a >= 'h08 && a <= 'h0C) ||
               a == 'h40 || a == 'h44 || a == 'h50 || a == 'h54;
    endfunction

    function automatic bit size_ok(input int s);
        return s == 1 || s == 2 || s == 4;
    endfunction

    function automatic logic [31:0] exp_read(input int a);
        if (a == 'h00) return {31'b0, ctrl_m};
        if (a == 'h04) return exp_cfg(N_CORES);
        if (a >= 'h08 && a <= 'h0B) return stat_m >> (8 * (a - 'h08));
        return '0;
    endfunction

    task automatic mdl_write(input int a, input logic [31:0] d, input int s);
        if (!size_ok(s)) return;
        if (a == 'h00) ctrl_m = d[0];
        if (a >= 'h08 && a <= 'h0B) begin
            for (int j = 0; j < s; j++)
                if ((a - 'h08) + j < 4)
                    stat_m[8*((a - 'h08) + j) +: 8] = d[8*j +: 8];
        end
    endtask

    // one bus cycle; rd/wr may both be set (R9 collision)
    task automatic bus(input bit r, input bit w, input int a,
                       input logic [31:0] d, input int s, input string req);
        logic [31:0] exp_rd;
        logic [31:0] prev_rd;
        exp_rd  = exp_read(a);
        prev_rd = rdata;
        @(negedge clk);
        rd_en = r; wr_en = w; addr = ADDR_W'(a); wdata = d; size = 3'(s);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        if (w) mdl_write(a, d, s);
        if (r) chk(rdata == exp_rd, req, rdata, exp_rd);
        else   chk(rdata == prev_rd, "R9 hold", rdata, prev_rd);
        chk(dec_err == ((r || w) && !is_known(a)), "R8 dec_err", 32'(dec_err),
            32'((r || w) && !is_known(a)));
        chk(size_err == (w && !size_ok(s)), "R6 size_err", 32'(size_err),
            32'(w && !size_ok(s)));
    endtask

    task automatic rd(input int a, input string req);
        bus(1'b1, 1'b0, a, 32'h0, 4, req);
    endtask

    task automatic wr(input int a, input logic [31:0] d, input int s, input string req);
        bus(1'b0, 1'b1, a, d, s, req);
    endtask

    initial begin
        int addrs[12] = '{'h00, 'h04, 'h08, 'h09, 'h0A, 'h0B, 'h0C, 'h40,
                          'h44, 'h50, 'h54, 'h10};
        logic [31:0] held;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(rdata == 0, "R1 rdata", rdata, 0);
        chk(size_err == 0, "R1 size_err", 32'(size_err), 0);
        chk(dec_err == 0, "R1 dec_err", 32'(dec_err), 0);
        rd('h00, "R1 ctrl");
        for (int k = 0; k < 4; k++) rd('h08 + k, "R1 status");

        // R2 control bit only
        wr('h00, 32'hFFFF_FFFE, 4, "R2 write");
        rd('h00, "R2 even");
        wr('h00, 32'hFFFF_FFFF, 1, "R2 write");
        rd('h00, "R2 bit0");

        // R3 config read-only
        wr('h04, 32'h1234_5678, 4, "R3 write");
        rd('h04, "R3 cfg");
        chk(rdata == 32'h72, "R3 cfg literal", rdata, 32'h72);

        // R5/R4 lanes and truncation
        wr('h08, 32'h4433_2211, 4, "R5 word");
        for (int k = 0; k < 4; k++) rd('h08 + k, "R4 shift");
        wr('h0B, 32'h0000_ABCD, 2, "R5 trunc");
        rd('h08, "R5 trunc");
        chk(rdata == 32'hCD33_2211, "R5 trunc literal", rdata, 32'hCD33_2211);
        wr('h09, 32'hDEAD_BEEF, 4, "R5 word off1");
        rd('h08, "R5 off1");
        wr('h0A, 32'h0000_0077, 1, "R5 byte");
        rd('h08, "R5 byte");

        // R6 bad sizes
        wr('h08, 32'hFFFF_FFFF, 3, "R6 drop");
        rd('h08, "R6 status");
        wr('h00, 32'h0, 0, "R6 drop ctrl");
        rd('h00, "R6 ctrl");

        // R7 inert offsets
        wr('h0C, 32'hFFFF_FFFF, 4, "R7 inv");
        wr('h40, 32'hFFFF_FFFF, 4, "R7 filt");
        rd('h40, "R7 filt");
        rd('h54, "R7 acs");
        rd('h08, "R7 state");

        // R8 unmapped
        wr('h10, 32'hFFFF_FFFF, 4, "R8 write");
        rd('h10, "R8 read");
        rd('h08, "R8 state");

        // R9 hold and collision
        held = rdata;
        repeat (3) @(negedge clk);
        chk(rdata == held, "R9 idle hold", rdata, held);
        chk(dec_err == 0, "R8 pulse ended", 32'(dec_err), 0);
        bus(1'b1, 1'b1, 'h08, 32'h5555_5555, 4, "R9 collision old");
        rd('h08, "R9 after collision");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int a, s, sel;
            logic [31:0] d;
            sel = int'($urandom % 16);
            a = (sel < 12) ? addrs[sel] : int'($urandom % 256);
            s = ($urandom % 4 != 0) ? ((1 << ($urandom % 3))) : int'($urandom % 8);
            d = $urandom;
            case ($urandom % 3)
                0:       bus(1'b1, 1'b0, a, d, s, "R4 random read");
                1:       bus(1'b0, 1'b1, a, d, s, "R5 random write");
                default: bus(1'b1, 1'b1, a, d, s, "R9 random mix");
            endcase
        end
        summary();
    end
endmodule